// File: doc/BRIEF.md
# Cascaded Pulse Accumulator Counter

This block is a 16-bit pulse accumulator made of two 8-bit byte counters. The low byte carries into the high byte. It runs in one of two modes:

- **Event mode:** it counts the selected transitions on a single timer input pin.
- **Gated mode:** it counts ticks of an internally divided clock while that pin holds its active level.

Two status flags live in a small flag register:

- an input-edge flag, set by a counted edge or by the end of a gate window;
- an overflow flag, set when the 16-bit count wraps.

Each flag drives an interrupt line through its own enable input.

Software reaches the block over a synchronous bus with read data returned one cycle later. It can read or write the two count bytes one at a time, or move both bytes in a single word access. A word access avoids the split-read hazard where a carry lands between two byte reads. Flags are cleared in one of two ways:

- by writing a one to their bit, or
- when fast clear is enabled, as a side effect of any count access.

Top module: `pacc_top`

## Requirements
- R1: After a synchronous reset, both count bytes read 0x00, both flags read 0 and both interrupt outputs are low.
- R2: In event mode (gated_mode=0) with acc_en=1, the 16-bit count increments once per selected pin transition: rising when edge_sel=1, falling when edge_sel=0. The low byte carries into the high byte (0x00FE plus two edges gives 0x0100).
- R3: The overflow flag, bit 1 of the flag register, sets when an increment takes the count from 0xFFFF to 0x0000.
- R4: In event mode the input-edge flag, bit 0 of the flag register, sets on every counted pin transition.
- R5: In gated mode (gated_mode=1) the pin's active level is high when edge_sel=1 and low when edge_sel=0. While the synchronized pin is at its active level, the count increments once per DIV clock cycles, counting from the start of the window. The input-edge flag sets only on the trailing (active-to-inactive) transition of the pin.
- R6: A write to address 0 clears flag bit n wherever the written bit n is 1. Bits written as 0 leave their flags unchanged.
- R7: With fast_clr_en=1, any read or write of a count address (1 or 2) clears both flags. With fast_clr_en=0, such an access leaves the flags unchanged.
- R8: The address map is as follows:
  - Address 2 is the low count byte.
  - Address 1 with bus_word=0 is the high byte.
  - Address 1 with bus_word=1 is the full count {high,low}.
  - Byte data travels on bits [7:0].
  - Read data appears on bus_rdata in the cycle after the request.
  - A count write takes priority over an increment in the same cycle.
- R9: With acc_en=0 the count holds its value, and pin activity sets neither flag.
- R10: irq_edge and irq_ovf go high one cycle after their flag and their enable (edge_ie, ovf_ie) are both set. They stay low while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Accumulator enable |
| gated_mode | input | 1 | 1 = gated time accumulation, 0 = event counting |
| edge_sel | input | 1 | Counted edge (event mode) or active gate level (gated mode); 1 = rising/high |
| fast_clr_en | input | 1 | Count access clears all flags |
| edge_ie | input | 1 | Input-edge interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| pin_in | input | 1 | Asynchronous timer input pin |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 16-bit word access at address 1 |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq_edge | output | 1 | Input-edge interrupt |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
Each kind of internal fault shows up at the ports in a predictable way:

- A broken carry between the two count bytes is visible at the first word read after 0x00FF is crossed. A wrong wrap detector shows up in the flag register right after the 0xFFFF edge.
- A synchronizer or edge detector that picks the wrong transition leaves the count short or long by one per pulse. Gated mode also shifts the edge flag from the trailing edge to the leading one, and a flag read during the gate window catches that.
- A stale prescaler phase changes the number of ticks in a window of fixed length.
- Faulty flag-clear logic survives a single write or count access, and the next flag read exposes it.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = 2;
  localparam int COUNT_W = BYTE_W * NBYTES;
  localparam int ADDR_W  = 2;
  localparam logic [ADDR_W-1:0] ADR_FLAGS = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_HIGH  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_LOW   = 2'd2;
  localparam int FBIT_EDGE = 0;
  localparam int FBIT_OVF  = 1;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic d_sync,
  output logic d_prev
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      d_prev <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], d_async};
      d_prev <= chain[STAGES-1];
    end
  end

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/pacc_prescale.sv
module pacc_prescale #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || !run)    phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                phase <= phase + 1'b1;
  end

  assign tick = run && (phase == LAST);
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     inc,
  input  logic [NBYTES-1:0]        wr_en,
  input  logic [NBYTES*BYTE_W-1:0] wdata,
  output logic [NBYTES*BYTE_W-1:0] count,
  output logic                     wrap
);
  logic [NBYTES:0] carry;
  logic            any_wr;

  assign any_wr   = |wr_en;
  assign carry[0] = inc && !any_wr;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] val;
    assign carry[i+1] = carry[i] && (&val);

    always_ff @(posedge clk) begin
      if (rst)           val <= '0;
      else if (wr_en[i]) val <= wdata[i*BYTE_W +: BYTE_W];
      else if (carry[i]) val <= val + 1'b1;
    end

    assign count[i*BYTE_W +: BYTE_W] = val;
  end

  assign wrap = carry[NBYTES];
endmodule

// File: rtl/pacc_top.sv
module pacc_top
  import pacc_pkg::*;
#(
  parameter int DIV         = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_en,
  input  logic               gated_mode,
  input  logic               edge_sel,
  input  logic               fast_clr_en,
  input  logic               edge_ie,
  input  logic               ovf_ie,
  input  logic               pin_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_word,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [COUNT_W-1:0] bus_wdata,
  output logic [COUNT_W-1:0] bus_rdata,
  output logic               irq_edge,
  output logic               irq_ovf
);
  logic pin_s, pin_p, rise, fall, active_lvl;
  logic event_edge, trail_edge, tick, run;
  logic inc, ovf_wrap, edge_set, ovf_set;
  logic hit_hi, hit_lo, cnt_access, flag_wr;
  logic [NBYTES-1:0]  cnt_wr;
  logic [COUNT_W-1:0] cnt_wdata, count;
  logic flag_edge, flag_ovf, clr_edge, clr_ovf;

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(pin_in), .d_sync(pin_s), .d_prev(pin_p)
  );

  assign rise       = pin_s && !pin_p;
  assign fall       = !pin_s && pin_p;
  assign active_lvl = (pin_s == edge_sel);
  assign event_edge = edge_sel ? rise : fall;
  assign trail_edge = edge_sel ? fall : rise;
  assign run        = acc_en && gated_mode && active_lvl;

  pacc_prescale #(.DIV(DIV)) u_pre (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  assign inc      = acc_en && (gated_mode ? tick : event_edge);
  assign edge_set = acc_en && (gated_mode ? trail_edge : event_edge);

  assign hit_hi     = bus_sel && (bus_addr == ADR_HIGH);
  assign hit_lo     = bus_sel && ((bus_addr == ADR_LOW) || ((bus_addr == ADR_HIGH) && bus_word));
  assign cnt_access = hit_hi || hit_lo;
  assign cnt_wr     = {hit_hi && bus_wr, hit_lo && bus_wr};
  assign cnt_wdata  = bus_word ? bus_wdata : {bus_wdata[BYTE_W-1:0], bus_wdata[BYTE_W-1:0]};
  assign flag_wr    = bus_sel && bus_wr && (bus_addr == ADR_FLAGS);

  pacc_counter #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_cnt (
    .clk(clk), .rst(rst), .inc(inc), .wr_en(cnt_wr), .wdata(cnt_wdata),
    .count(count), .wrap(ovf_wrap)
  );

  assign ovf_set  = ovf_wrap;
  assign clr_edge = (flag_wr && bus_wdata[FBIT_EDGE]) || (fast_clr_en && cnt_access);
  assign clr_ovf  = (flag_wr && bus_wdata[FBIT_OVF])  || (fast_clr_en && cnt_access);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_edge <= 1'b0;
      flag_ovf  <= 1'b0;
      irq_edge  <= 1'b0;
      irq_ovf   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (edge_set)      flag_edge <= 1'b1;
      else if (clr_edge) flag_edge <= 1'b0;
      if (ovf_set)       flag_ovf  <= 1'b1;
      else if (clr_ovf)  flag_ovf  <= 1'b0;
      irq_edge <= flag_edge && edge_ie;
      irq_ovf  <= flag_ovf && ovf_ie;
      if (bus_sel && !bus_wr) begin
        unique case (bus_addr)
          ADR_FLAGS: bus_rdata <= {{(COUNT_W-2){1'b0}}, flag_ovf, flag_edge};
          ADR_HIGH:  bus_rdata <= bus_word ? count
                                           : {{BYTE_W{1'b0}}, count[COUNT_W-1 -: BYTE_W]};
          ADR_LOW:   bus_rdata <= {{BYTE_W{1'b0}}, count[BYTE_W-1:0]};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk
  import pacc_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               acc_en,
  input logic               fast_clr_en,
  input logic [COUNT_W-1:0] count,
  input logic [NBYTES-1:0]  cnt_wr,
  input logic               cnt_access,
  input logic               flag_wr,
  input logic [COUNT_W-1:0] bus_wdata,
  input logic               flag_edge,
  input logic               flag_ovf,
  input logic               edge_set,
  input logic               ovf_wrap
);
  // R9: disabled and unwritten count stays put
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(acc_en) && ($past(cnt_wr) == '0)) |-> $stable(count));

  // R9: no edge flag arises while disabled
  a_r9_no_flag: assert property (@(posedge clk) disable iff (rst)
    (!$past(acc_en) && !$past(flag_edge)) |-> !flag_edge);

  // R3: counter wrap raises the overflow flag
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    $past(ovf_wrap) |-> flag_ovf);

  // R6: write-one clears overflow when no wrap competes
  a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
    $past(flag_wr && bus_wdata[FBIT_OVF] && !ovf_wrap) |-> !flag_ovf);

  // R7: fast clear on count access
  a_r7_fast_clr: assert property (@(posedge clk) disable iff (rst)
    $past(fast_clr_en && cnt_access && !edge_set && !ovf_wrap) |-> (!flag_edge && !flag_ovf));
endmodule

bind pacc_top pacc_chk u_chk (
  .clk(clk), .rst(rst), .acc_en(acc_en), .fast_clr_en(fast_clr_en),
  .count(count), .cnt_wr(cnt_wr), .cnt_access(cnt_access), .flag_wr(flag_wr),
  .bus_wdata(bus_wdata), .flag_edge(flag_edge), .flag_ovf(flag_ovf),
  .edge_set(edge_set), .ovf_wrap(ovf_wrap)
);

// File: tb/sim_pacc_top.sv
module sim_pacc_top;
  localparam int DIV = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_en = 0, gated_mode = 0, edge_sel = 1, fast_clr_en = 0;
  logic edge_ie = 0, ovf_ie = 0, pin_in = 0;
  logic bus_sel = 0, bus_wr = 0, bus_word = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic irq_edge, irq_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pacc_top #(.DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .acc_en(acc_en), .gated_mode(gated_mode),
    .edge_sel(edge_sel), .fast_clr_en(fast_clr_en), .edge_ie(edge_ie),
    .ovf_ie(ovf_ie), .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_edge(irq_edge), .irq_ovf(irq_ovf)
  );

  // {edge_sel, pulses, start, expected count, expected flags {ovf,edge}}
  localparam logic [38:0] VEC [6] = '{
    {1'b1, 4'd3, 16'h0000, 16'h0003, 2'b01},
    {1'b0, 4'd2, 16'h00FE, 16'h0100, 2'b01},
    {1'b1, 4'd1, 16'hFFFF, 16'h0000, 2'b11},
    {1'b0, 4'd4, 16'h1234, 16'h1238, 2'b01},
    {1'b1, 4'd0, 16'h0010, 16'h0010, 2'b00},
    {1'b0, 4'd1, 16'hFFFF, 16'h0000, 2'b11}
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bwrite(input logic [1:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_word = w; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_word = 0;
  endtask

  task automatic bread(input logic [1:0] a, input logic w, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_word = w; bus_addr = a;
    @(negedge clk);
    bus_sel = 0; bus_word = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic act);
    @(negedge clk); pin_in = act;
    wait_cyc(3);
    pin_in = ~act;
    wait_cyc(3);
  endtask

  initial begin
    wait_cyc(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    wait_cyc(3);
    rst = 0;
    wait_cyc(1);

    // R1 reset state
    check("R1 irq_edge", {15'd0, irq_edge}, 16'd0);
    check("R1 irq_ovf", {15'd0, irq_ovf}, 16'd0);
    bread(2'd1, 1, rd); check("R1 count", rd, 16'h0000);
    bread(2'd0, 0, rd); check("R1 flags", rd, 16'h0000);

    // R2 R3 R4 R8: table of event-mode runs
    acc_en = 1;
    foreach (VEC[k]) begin
      edge_sel = VEC[k][38];
      pin_in = ~VEC[k][38];
      wait_cyc(4);
      bwrite(2'd0, 0, 16'h0003);
      bwrite(2'd1, 1, VEC[k][33:18]);
      for (int p = 0; p < int'(VEC[k][37:34]); p++) pulse(VEC[k][38]);
      wait_cyc(4);
      bread(2'd1, 1, rd); check("R2 event count", rd, VEC[k][17:2]);
      bread(2'd0, 0, rd); check("R3 R4 flags", rd, {14'd0, VEC[k][1:0]});
    end

    // R8 byte access
    bwrite(2'd1, 0, 16'h0012);
    bwrite(2'd2, 0, 16'h0034);
    bread(2'd1, 1, rd); check("R8 word read", rd, 16'h1234);
    bread(2'd1, 0, rd); check("R8 high byte", rd, 16'h0012);
    bread(2'd2, 0, rd); check("R8 low byte", rd, 16'h0034);

    // R10 interrupts and R6 clearing
    edge_sel = 1; pin_in = 0; wait_cyc(4);
    bwrite(2'd1, 1, 16'hFFFF);
    pulse(1'b1); wait_cyc(2);
    edge_ie = 1; ovf_ie = 0; wait_cyc(2);
    check("R10 irq_edge on", {15'd0, irq_edge}, 16'd1);
    check("R10 irq_ovf masked", {15'd0, irq_ovf}, 16'd0);
    ovf_ie = 1; wait_cyc(2);
    check("R10 irq_ovf on", {15'd0, irq_ovf}, 16'd1);
    bwrite(2'd0, 0, 16'h0000);
    bread(2'd0, 0, rd); check("R6 zero write", rd, 16'h0003);
    bwrite(2'd0, 0, 16'h0001);
    bread(2'd0, 0, rd); check("R6 clear edge", rd, 16'h0002);
    bwrite(2'd0, 0, 16'h0002);
    bread(2'd0, 0, rd); check("R6 clear ovf", rd, 16'h0000);
    wait_cyc(2);
    check("R10 irq_ovf off", {15'd0, irq_ovf}, 16'd0);

    // R7 fast clear
    pulse(1'b1); wait_cyc(4);
    bread(2'd2, 0, rd);
    bread(2'd0, 0, rd); check("R7 no fast clear", rd, 16'h0001);
    fast_clr_en = 1;
    bread(2'd2, 0, rd);
    bread(2'd0, 0, rd); check("R7 fast clear", rd, 16'h0000);
    fast_clr_en = 0;

    // R9 disabled
    bwrite(2'd1, 1, 16'h0055);
    acc_en = 0;
    pulse(1'b1); pulse(1'b1); wait_cyc(4);
    bread(2'd1, 1, rd); check("R9 hold", rd, 16'h0055);
    bread(2'd0, 0, rd); check("R9 no flags", rd, 16'h0000);

    // R5 gated mode, active high
    acc_en = 1; gated_mode = 1; edge_sel = 1; pin_in = 0;
    wait_cyc(4);
    bwrite(2'd1, 1, 16'h0000);
    bwrite(2'd0, 0, 16'h0003);
    @(negedge clk); pin_in = 1;
    wait_cyc(3 * DIV + DIV / 2);
    bread(2'd0, 0, rd); check("R5 no flag on leading", rd, 16'h0000);
    pin_in = 0;
    wait_cyc(6);
    bread(2'd1, 1, rd); check("R5 gated count", rd, 16'h0003);
    bread(2'd0, 0, rd); check("R5 trailing flag", rd, 16'h0001);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule